// File: doc/BRIEF.md
# Bitmask Logical Immediate Decoder

This block turns a packed 13-bit logical-immediate field into the bit mask it stands for. The field holds a wide-element flag, a rotate count and a run-length code. From these the block works out an element width that is a power of two, places a run of ones at the bottom of one element, rotates that run right inside the element, and repeats the element across the register. A size input picks a 32-bit or a 64-bit register. A 32-bit result sits in the low half and the upper half reads zero.

Some field values do not describe a mask. The block marks each of them with an illegal flag and forces the mask to zero. Every result is registered, so it appears one cycle after its input, together with an output valid. An execution pipeline can use the block next to its operand fetch to produce constant operands for AND, OR and XOR style operations.

Top module: `bitmask_imm_expander`

## Requirements
- R1: The field is packed as the wide flag in bit 12, the rotate count in bits 11..6 and the run-length code in bits 5..0. For example, field 0x1000 with the 64-bit size gives mask 0x1, and field 0x1040 gives 0x8000000000000000.
- R2: The element width is 2^k, where k is the index of the highest set bit of the 7-bit value {bit 12, inverted bits 5..0}. If that value is zero, the field is illegal.
- R3: An element holds S+1 ones in its low bits, where S is bits 5..0 masked to k bits. It is rotated right by R bits within the element, where R is bits 11..6 masked to k bits.
- R4: An element narrower than the register is repeated to fill the whole register width.
- R5: A field whose masked S equals the element width minus one is illegal. This includes every field that decodes to a 1-bit element.
- R6: With the 32-bit size selected (size input 0), any field with bit 12 set is illegal.
- R7: With the 32-bit size selected, mask bits 63..32 are zero, and bits 31..0 hold the repeated pattern.
- R8: When the illegal flag is set, the mask output is zero.
- R9: Mask, illegal flag and output valid appear on the clock edge after the input is accepted. The output valid is high exactly one cycle after each cycle in which the input valid is high.
- R10: A synchronous active-low reset clears the output valid, the mask and the illegal flag, whatever the input valid is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The field and size inputs are valid this cycle |
| imm_field | input | 13 | Packed field: wide flag, rotate count, run-length code |
| size_sel | input | 1 | Register size: 0 for 32-bit, 1 for 64-bit |
| out_valid | output | 1 | Registered result is valid |
| out_mask | output | 64 | Decoded mask; zero when illegal; upper half zero in 32-bit mode |
| out_illegal | output | 1 | The field does not describe a mask |

## Verification
The bench builds the block with its default subfield width of 6, which gives a 13-bit field and a 64-bit register. At that width every one of the 8192 field values can be driven at both register sizes. This covers every element width from 2 to 64, every rotate count, and every illegal case: a zero size probe, an all-ones element, and the wide flag in 32-bit mode. A behavioural model in the bench computes each expected value, using a bit-by-bit rotation and a modulo-indexed repeat. A few hand-worked fields also pin down the field positions.

// File: rtl/bmx_pkg.sv
// Package bmx_pkg
// Shared constants and types of the bitmask immediate decoder.
// Assumes: the subfield width sets every other width of the block.
package bmx_pkg;

    // Width of each of the rotate and run-length subfields
    localparam int unsigned BMX_SUBFIELD_W = 6;

    // Register size select encoding
    typedef enum logic {
        BMX_SZ32 = 1'b0,
        BMX_SZ64 = 1'b1
    } bmx_size_e;

endpackage

// File: rtl/bmx_size_detect.sv
// Module bmx_size_detect
// Works out the element width from the wide flag and the run-length code.
// It also returns the masked rotate and run values and flags illegal fields.
// Assumes: FW-bit subfields, so the size probe is FW+1 bits wide.
module bmx_size_detect #(
    parameter int unsigned FW    = 6,
    parameter int unsigned LEN_W = $clog2(FW + 1)
) (
    input  logic             n_bit,
    input  logic [FW-1:0]    rot_code,
    input  logic [FW-1:0]    run_code,
    input  logic             wide,
    output logic [FW-1:0]    size_m1,
    output logic [FW-1:0]    rot_amt,
    output logic [FW-1:0]    run_len,
    output logic             illegal
);

    logic [FW:0]      probe;
    logic [LEN_W-1:0] len;
    logic [FW:0]      size_full;

    // Find the highest set bit of the size probe
    always_comb begin
        probe = {n_bit, ~run_code};
        len   = '0;
        for (int i = 0; i <= int'(FW); i++) begin
            if (probe[i]) len = LEN_W'(i);
        end
    end

    // Derive the element mask and the masked subfields
    always_comb begin
        size_full = (FW + 1)'(1) << len;
        size_m1   = FW'(size_full - (FW + 1)'(1));
        rot_amt   = rot_code & size_m1;
        run_len   = run_code & size_m1;
    end

    // Combine the three illegal conditions
    always_comb begin
        illegal = (probe == '0) || (run_len == size_m1) || (!wide && n_bit);
    end

endmodule

// File: rtl/bmx_elem_build.sv
// Module bmx_elem_build
// Builds one element: a run of ones rotated right within the element width.
// Assumes: run_len < size_m1, which the caller guarantees for legal fields.
module bmx_elem_build #(
    parameter int unsigned FW    = 6,
    parameter int unsigned REG_W = 1 << FW
) (
    input  logic [FW-1:0]    run_len,
    input  logic [FW-1:0]    rot_amt,
    input  logic [FW-1:0]    size_m1,
    output logic [REG_W-1:0] elem
);

    logic [REG_W-1:0] ones;
    logic [REG_W-1:0] window;
    logic [FW:0]      back_sh;

    // Per-bit run and window masks
    for (genvar i = 0; i < int'(REG_W); i++) begin : g_bits
        localparam logic [FW:0] IDX = (FW + 1)'(i);
        assign ones[i]   = (IDX <= {1'b0, run_len});
        assign window[i] = (IDX <= {1'b0, size_m1});
    end

    // Rotate right inside the element; bits pushed past the window are cut off
    always_comb begin
        back_sh = {1'b0, size_m1} + (FW + 1)'(1) - {1'b0, rot_amt};
        elem    = ((ones >> rot_amt) | (ones << back_sh)) & window;
    end

endmodule

// File: rtl/bmx_replicate.sv
// Module bmx_replicate
// Repeats one element across the register, and clears the upper half in
// narrow mode.
// Assumes: the element sits in the low bits and its width is a power of two.
module bmx_replicate #(
    parameter int unsigned FW    = 6,
    parameter int unsigned REG_W = 1 << FW
) (
    input  logic [REG_W-1:0] elem,
    input  logic [FW-1:0]    size_m1,
    input  logic             wide,
    output logic [REG_W-1:0] mask
);

    localparam int unsigned HALF = REG_W / 2;

    // Each output bit copies the element bit at the same position modulo the width
    for (genvar i = 0; i < int'(REG_W); i++) begin : g_rep
        localparam logic [FW-1:0] IDX = FW'(i);
        if (i >= int'(HALF)) begin : g_hi
            assign mask[i] = wide & elem[IDX & size_m1];
        end else begin : g_lo
            assign mask[i] = elem[IDX & size_m1];
        end
    end

endmodule

// File: rtl/bitmask_imm_expander.sv
// Module bitmask_imm_expander
// Top level: decodes a packed logical-immediate field into a register-wide
// mask, with an illegal flag, and registers the result.
// Assumes: the field holds {wide flag, rotate count, run-length code}, each
// count FW bits wide.
module bitmask_imm_expander #(
    parameter int unsigned FW      = bmx_pkg::BMX_SUBFIELD_W,
    parameter int unsigned REG_W   = 1 << FW,
    parameter int unsigned FIELD_W = 2 * FW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FIELD_W-1:0] imm_field,
    input  logic               size_sel,
    output logic               out_valid,
    output logic [REG_W-1:0]   out_mask,
    output logic               out_illegal
);

    import bmx_pkg::*;

    localparam int unsigned HALF = REG_W / 2;

    logic             wide;
    logic             n_bit;
    logic [FW-1:0]    rot_code;
    logic [FW-1:0]    run_code;
    logic [FW-1:0]    size_m1;
    logic [FW-1:0]    rot_amt;
    logic [FW-1:0]    run_len;
    logic             bad;
    logic [REG_W-1:0] elem;
    logic [REG_W-1:0] rep;

    // Split the packed field into its parts
    always_comb begin
        wide     = (bmx_size_e'(size_sel) == BMX_SZ64);
        n_bit    = imm_field[FIELD_W-1];
        rot_code = imm_field[2*FW-1:FW];
        run_code = imm_field[FW-1:0];
    end

    bmx_size_detect #(.FW(FW)) u_size (
        .n_bit    (n_bit),
        .rot_code (rot_code),
        .run_code (run_code),
        .wide     (wide),
        .size_m1  (size_m1),
        .rot_amt  (rot_amt),
        .run_len  (run_len),
        .illegal  (bad)
    );

    bmx_elem_build #(.FW(FW), .REG_W(REG_W)) u_elem (
        .run_len (run_len),
        .rot_amt (rot_amt),
        .size_m1 (size_m1),
        .elem    (elem)
    );

    bmx_replicate #(.FW(FW), .REG_W(REG_W)) u_rep (
        .elem    (elem),
        .size_m1 (size_m1),
        .wide    (wide),
        .mask    (rep)
    );

    // Register the result; an illegal field gives a zero mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_mask    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mask    <= bad ? '0 : rep;
                out_illegal <= bad;
            end
        end
    end

    // Output valid follows input valid by one cycle
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // An illegal result carries a zero mask
    assert_zero_on_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_mask == '0));

    // A wide flag with the narrow size is always illegal
    assert_narrow_wide_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !size_sel && imm_field[FIELD_W-1]) |=> out_illegal);

    // A narrow result leaves the upper half clear
    assert_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !size_sel) |=> (out_mask[REG_W-1:HALF] == '0));

    // A legal element is never empty and never all ones
    assert_legal_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal) |-> (out_mask != '0 && out_mask != '1));

endmodule

// File: tb/test_bitmask_imm_expander.sv
module test_bitmask_imm_expander;

    typedef struct {
        logic [63:0] mask;
        logic        ill;
        logic [12:0] field;
        logic        wide;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [12:0] imm_field = '0;
    logic        size_sel = 1'b0;
    logic        out_valid;
    logic [63:0] out_mask;
    logic        out_illegal;

    int total = 0;
    int bad = 0;
    int pushed = 0;
    int popped = 0;
    bit done = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    bitmask_imm_expander i_bitmask_imm_expander (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .imm_field   (imm_field),
        .size_sel    (size_sel),
        .out_valid   (out_valid),
        .out_mask    (out_mask),
        .out_illegal (out_illegal)
    );

    // Behavioural reference: bit-by-bit rotation and modulo repeat
    function automatic exp_t model(logic [12:0] f, logic wide);
        exp_t e;
        logic [6:0]  probe;
        logic [63:0] pat;
        int len, size, r, s;
        e.field = f; e.wide = wide; e.mask = '0; e.ill = 1'b0;
        probe = {f[12], ~f[5:0]};
        len = -1;
        for (int b = 6; b >= 0; b--) if (probe[b] && len < 0) len = b;
        if (len < 0) begin e.ill = 1'b1; e.tag = "R2 R8"; return e; end
        size = 1 << len;
        r = int'(f[11:6]) % size;
        s = int'(f[5:0]) % size;
        if (s == size - 1) begin e.ill = 1'b1; e.tag = "R5 R8"; return e; end
        if (f[12] && !wide) begin e.ill = 1'b1; e.tag = "R6 R8"; return e; end
        pat = '0;
        for (int k = 0; k <= s; k++) pat[k] = 1'b1;
        for (int k = 0; k < r; k++) pat = ({63'b0, pat[0]} << (size - 1)) | (pat >> 1);
        for (int k = 0; k < 64; k++) e.mask[k] = pat[k % size];
        if (!wide) e.mask[63:32] = '0;
        e.tag = !wide ? "R7 R3" : (size < 64 ? "R4 R3" : "R3");
        return e;
    endfunction

    task automatic note(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one field and push its expected result
    task automatic send(logic [12:0] f, logic wide, exp_t e);
        @(negedge clk);
        in_valid = 1'b1; imm_field = f; size_sel = wide;
        sb.push_back(e);
        pushed++;
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0; imm_field = 13'h1fff;
        @(posedge clk); #5;
        note(out_valid == 1'b0, "R9", "idle valid", 64'(out_valid), 64'd0);
    endtask

    function automatic exp_t hand(logic [12:0] f, logic wide, logic [63:0] m, logic il, string tag);
        exp_t e;
        e.field = f; e.wide = wide; e.mask = m; e.ill = il; e.tag = tag;
        return e;
    endfunction

    // Monitor: pop and compare each result
    initial begin
        forever begin
            @(posedge clk); #5;
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    note(1'b0, "R9", "unexpected valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    popped++;
                    total++;
                    if (out_mask !== e.mask || out_illegal !== e.ill) begin
                        bad++;
                        $display("FAIL %s field=%h wide=%0d mask act=%h exp=%h ill act=%0d exp=%0d",
                                 e.tag, e.field, e.wide, out_mask, e.mask, out_illegal, e.ill);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus
    initial begin
        // R10: reset holds outputs clear while the input valid is high
        in_valid = 1'b1; imm_field = 13'h1000; size_sel = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        note(out_valid == 1'b0, "R10", "reset valid", 64'(out_valid), 64'd0);
        note(out_mask == '0, "R10", "reset mask", out_mask, 64'd0);
        note(out_illegal == 1'b0, "R10", "reset illegal", 64'(out_illegal), 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle_check();

        // R1: field positions pinned by hand
        send(13'h1000, 1'b1, hand(13'h1000, 1'b1, 64'h1, 1'b0, "R1"));
        send(13'h1040, 1'b1, hand(13'h1040, 1'b1, 64'h8000000000000000, 1'b0, "R1"));
        // R4: 2-bit element repeated at both sizes
        send(13'h003c, 1'b1, hand(13'h003c, 1'b1, 64'h5555555555555555, 1'b0, "R4"));
        send(13'h003c, 1'b0, hand(13'h003c, 1'b0, 64'h0000000055555555, 1'b0, "R4 R7"));
        // R3: 4 ones rotated right by 4 in a 32-bit element
        send(13'h0103, 1'b0, hand(13'h0103, 1'b0, 64'h00000000f0000000, 1'b0, "R3 R7"));
        send(13'h0103, 1'b1, hand(13'h0103, 1'b1, 64'hf0000000f0000000, 1'b0, "R3 R4"));
        // R6: wide flag in narrow mode
        send(13'h1000, 1'b0, hand(13'h1000, 1'b0, 64'h0, 1'b1, "R6 R8"));
        // R2: zero size probe
        send(13'h003f, 1'b1, hand(13'h003f, 1'b1, 64'h0, 1'b1, "R2 R8"));
        idle_check();

        // Full sweep against the model at both sizes
        for (int w = 0; w < 2; w++) begin
            for (int f = 0; f < 8192; f++) begin
                send(13'(f), 1'(w), model(13'(f), 1'(w)));
            end
            idle_check();
        end

        repeat (3) @(negedge clk);
        note(sb.size() == 0 && pushed == popped, "R9", "results outstanding",
             64'(popped), 64'(pushed));
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule